// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This block holds the replacement state of a set-associative cache. Each set keeps a binary tree of direction bits, one bit for each internal node, so a set with N ways needs N-1 bits. Walking the tree from the root and following each bit gives the way to evict. Recording an access makes every node on the path to that way point away from it, so the way just used is never the next one chosen.

The cache controller drives the update port whenever a way is accessed: on a hit, and also when a missing line is filled into the victim way. It reads the query port on a miss to learn which way of the indexed set to evict. The query result is combinational from the current state. An update changes the state at the next rising clock edge. The associativity must be a power of two, at least 2. The number of sets must be a power of two, at least 2.

Top module: `tree_plru_repl`

## Requirements
- R1: After a synchronous active-low reset, every set reports way 0 as its victim.
- R2: `victim_way` is combinational from `qry_set` and the stored state. Changing `qry_set` changes the result within the same cycle, with no clock edge needed.
- R3: An update is sampled at a rising edge when `upd_en` is 1. Its effect appears only after that edge. Before the edge, a query of the same set still returns the old victim.
- R4: An update changes the state of the set `upd_set` and no other set.
- R5: While `upd_en` is 0, no set's state changes.
- R6: Walk rule. The nodes are numbered heap-style: the root is node 0, and the children of node i are 2i+1 and 2i+2. A node bit of 0 selects the lower-numbered half and leads to child 2i+1. A node bit of 1 selects the upper half and leads to child 2i+2. The bit taken at the root is the most significant bit of the victim way.
- R7: Update rule. For the accessed way, each node on the root-to-leaf path is set to the inverse of the way bit that selects that node's branch. All other nodes of the set keep their values. With 8 ways, touching ways 0,4,2,6,1,5,3,7 one after another from reset makes the victim 4,2,6,1,5,3,7,0 after each touch.
- R8: Right after an update of way w in a set, the victim of that set is not w.
- R9: A fill of the current victim way goes through the same update as a hit. Afterwards, the set's victim moves to a different way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears every tree |
| upd_en | input | 1 | Records an access to `upd_way` in `upd_set` at the next edge |
| upd_set | input | $clog2(NUM_SETS) | Set index of the access |
| upd_way | input | $clog2(NUM_WAYS) | Way that was accessed or filled |
| qry_set | input | $clog2(NUM_SETS) | Set index being looked up on a miss |
| victim_way | output | $clog2(NUM_WAYS) | Way to evict from `qry_set` |

## Verification
The bench builds the block with 8 ways and 16 sets. Eight ways give a three-level tree, so the middle level is exercised. Those nodes are neither the root nor the parents of leaves, and an error in the path prefix match for them can only appear at this depth. With 16 sets, a reset sweep over every set stays short. The set index is still wide enough to place two updates in neighbouring sets and confirm that they do not disturb each other. A bit-reversed touch order walks the victim through every way. A pseudo-random mix of hits and fills is then compared against a tree model built from the walk and update rules.

// File: rtl/plru_pkg.sv
`timescale 1ns/1ps
// plru_pkg: elaboration-time helpers shared by the tree replacement modules.
// Assumes heap numbering of tree nodes (root 0, children 2i+1 and 2i+2).
package plru_pkg;

    // Depth of node n in a heap-numbered binary tree (root is depth 0).
    function automatic int node_depth(input int n);
        int d;
        d = 0;
        for (int k = 0; k < 16; k++) begin
            if (((1 << (k + 1)) - 1) <= n) d = k + 1;
        end
        return d;
    endfunction

    // Position of node n among the nodes at its own depth, counted from the left.
    function automatic int node_rank(input int n);
        return n + 1 - (1 << node_depth(n));
    endfunction

endpackage

// File: rtl/plru_state_store.sv
`timescale 1ns/1ps
// plru_state_store: one word of tree node bits for each set.
// It has one write port and two combinational read ports: one read feeds the
// update path, the other feeds the victim query.
// Assumes every set index is below NUM_SETS (a power of two).
module plru_state_store #(
    parameter int NUM_SETS = 64,
    parameter int NODES    = 3,
    parameter int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [NODES-1:0] wr_bits,
    input  logic [SET_W-1:0] rd_set_a,
    output logic [NODES-1:0] rd_bits_a,
    input  logic [SET_W-1:0] rd_set_b,
    output logic [NODES-1:0] rd_bits_b
);

    logic [NODES-1:0] tree_q [NUM_SETS];

    // Clear every tree on reset; otherwise store the new tree of the updated set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
        end else if (wr_en) begin
            tree_q[wr_set] <= wr_bits;
        end
    end

    // Read ports are plain combinational selects of the stored words.
    assign rd_bits_a = tree_q[rd_set_a];
    assign rd_bits_b = tree_q[rd_set_b];

endmodule

// File: rtl/plru_victim_walk.sv
`timescale 1ns/1ps
// plru_victim_walk: walks one set's tree from the root to a leaf.
// At each node a 0 bit goes to the lower half and a 1 bit to the upper half.
// Each bit taken becomes the next victim bit, most significant bit first.
// Assumes NUM_WAYS is a power of two, at least 2.
module plru_victim_walk #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS),
    parameter int NODES    = NUM_WAYS - 1
) (
    input  logic [NODES-1:0] tree,
    output logic [WAY_W-1:0] victim
);

    logic [WAY_W-1:0] idx;
    logic             dir;

    // Follow the node bits level by level; idx tracks the heap node being visited.
    always_comb begin
        victim = '0;
        idx    = '0;
        dir    = 1'b0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            dir                   = tree[idx];
            victim[WAY_W-1-lvl]   = dir;
            idx = WAY_W'((32'(idx) << 1) + 32'd1 + 32'(dir));
        end
    end

endmodule

// File: rtl/plru_path_update.sv
`timescale 1ns/1ps
// plru_path_update: builds the next tree of a set after an access to one way.
// A node on the root-to-leaf path of the way is turned to point away from it.
// A node off that path keeps its value.
// Assumes NUM_WAYS is a power of two, at least 2.
module plru_path_update #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS),
    parameter int NODES    = NUM_WAYS - 1
) (
    input  logic [NODES-1:0] tree_q,
    input  logic [WAY_W-1:0] way,
    output logic [NODES-1:0] tree_d
);

    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int DEPTH = plru_pkg::node_depth(n);
        localparam int RANK  = plru_pkg::node_rank(n);
        if (DEPTH == 0) begin : g_root
            // The root lies on every path; point it at the other half.
            assign tree_d[n] = ~way[WAY_W-1];
        end else begin : g_inner
            // The node is on the path when the upper way bits equal its rank.
            assign tree_d[n] = (way[WAY_W-1 -: DEPTH] == DEPTH'(RANK))
                             ? ~way[WAY_W-1-DEPTH] : tree_q[n];
        end
    end

endmodule

// File: rtl/tree_plru_repl.sv
`timescale 1ns/1ps
// tree_plru_repl: per-set tree pseudo-LRU state with one update port and one
// victim query port. The query is combinational. An update is written at the
// next rising edge. At most one update is taken per cycle.
// Assumes NUM_SETS and NUM_WAYS are powers of two, each at least 2.
module tree_plru_repl #(
    parameter int NUM_SETS = 64,
    parameter int NUM_WAYS = 4,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim_way
);

    localparam int NODES = NUM_WAYS - 1;

    logic [NODES-1:0] upd_tree_q;
    logic [NODES-1:0] upd_tree_d;
    logic [NODES-1:0] qry_tree;

    // Storage for all sets.
    plru_state_store #(
        .NUM_SETS (NUM_SETS),
        .NODES    (NODES),
        .SET_W    (SET_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (upd_en),
        .wr_set    (upd_set),
        .wr_bits   (upd_tree_d),
        .rd_set_a  (upd_set),
        .rd_bits_a (upd_tree_q),
        .rd_set_b  (qry_set),
        .rd_bits_b (qry_tree)
    );

    // Next tree for the set being updated.
    plru_path_update #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W),
        .NODES    (NODES)
    ) update_i (
        .tree_q (upd_tree_q),
        .way    (upd_way),
        .tree_d (upd_tree_d)
    );

    // Victim choice for the queried set.
    plru_victim_walk #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W),
        .NODES    (NODES)
    ) walk_i (
        .tree   (qry_tree),
        .victim (victim_way)
    );

endmodule

// File: rtl/tree_plru_repl_checker.sv
`timescale 1ns/1ps
// tree_plru_repl_checker: port-level properties of the replacement unit.
// It is attached to every instance of tree_plru_repl by the bind below.
module tree_plru_repl_checker #(
    parameter int NUM_SETS = 64,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = $clog2(NUM_SETS),
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_en,
    input logic [SET_W-1:0] upd_set,
    input logic [WAY_W-1:0] upd_way,
    input logic [SET_W-1:0] qry_set,
    input logic [WAY_W-1:0] victim_way
);

    // R1: the first cycle out of reset shows way 0 for whichever set is queried.
    assert_reset_victim_R1: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (victim_way == '0));

    // R8: the way just recorded is not the victim of its set in the next cycle.
    assert_recent_not_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ((qry_set != $past(upd_set)) || (victim_way != $past(upd_way))));

    // R5: without an update and with the same query set, the victim holds.
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ((qry_set != $past(qry_set)) || (victim_way == $past(victim_way))));

    // R4: an update of a different set leaves the queried set's victim alone.
    assert_other_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (upd_set != qry_set))
        |=> ((qry_set != $past(qry_set)) || (victim_way == $past(victim_way))));

endmodule

bind tree_plru_repl tree_plru_repl_checker #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .upd_set    (upd_set),
    .upd_way    (upd_way),
    .qry_set    (qry_set),
    .victim_way (victim_way)
);

// File: tb/tree_plru_repl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for tree_plru_repl, built with 8 ways and 16 sets.
module tree_plru_repl_tb_top;

    localparam int SETS  = 16;
    localparam int WAYS  = 8;
    localparam int SW    = 4;
    localparam int WW    = 3;
    localparam int NN    = WAYS - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_en = 1'b0;
    logic [SW-1:0] upd_set = '0;
    logic [WW-1:0] upd_way = '0;
    logic [SW-1:0] qry_set = '0;
    logic [WW-1:0] victim_way;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [NN-1:0] mdl [SETS];
    logic [15:0]   lfsr = 16'hACE1;

    tree_plru_repl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_set(upd_set),
        .upd_way(upd_way), .qry_set(qry_set), .victim_way(victim_way)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Walk rule of R6 applied to the model tree.
    function automatic int mdl_victim(input int s);
        int idx = 0;
        int v   = 0;
        for (int l = 0; l < WW; l++) begin
            int b = int'(mdl[s][idx]);
            v   = (v << 1) | b;
            idx = 2 * idx + 1 + b;
        end
        return v;
    endfunction

    // Update rule of R7 applied to the model tree.
    task automatic mdl_touch(input int s, input int w);
        int idx = 0;
        for (int l = 0; l < WW; l++) begin
            int d = (w >> (WW - 1 - l)) & 1;
            mdl[s][idx] = (d == 0);
            idx = 2 * idx + 1 + d;
        end
    endtask

    // One update applied over one edge; inputs change at the falling edge.
    task automatic touch(input int s, input int w);
        @(negedge clk);
        upd_en  = 1'b1;
        upd_set = SW'(s);
        upd_way = WW'(w);
        @(negedge clk);
        upd_en  = 1'b0;
        mdl_touch(s, w);
    endtask

    function automatic int peek_set_victim(input int s);
        return mdl_victim(s);
    endfunction

    task automatic t_reset_all;
        for (int s = 0; s < SETS; s++) begin
            qry_set = SW'(s);
            #1;
            chk("R1 reset victim", int'(victim_way), 0);
        end
    endtask

    task automatic t_bit_reversed;
        int order [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        int expv  [8] = '{4, 2, 6, 1, 5, 3, 7, 0};
        for (int i = 0; i < 8; i++) begin
            touch(3, order[i]);
            qry_set = 4'd3;
            #1;
            chk("R7 R6 bit-reversed victim", int'(victim_way), expv[i]);
            chk("R8 touched way not victim", int'(victim_way != WW'(order[i])), 1);
        end
    endtask

    task automatic t_set_isolation;
        touch(5, 0);
        qry_set = 4'd6;
        #1;
        chk("R4 neighbour set untouched", int'(victim_way), 0);
        qry_set = 4'd4;
        #1;
        chk("R4 lower neighbour untouched", int'(victim_way), 0);
        qry_set = 4'd5;
        #1;
        chk("R6 updated set victim", int'(victim_way), 4);
    endtask

    task automatic t_enable_low;
        @(negedge clk);
        upd_en  = 1'b0;
        upd_set = 4'd5;
        upd_way = 3'd4;
        qry_set = 4'd5;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R5 disabled update ignored", int'(victim_way), 4);
    endtask

    task automatic t_timing;
        // R2: switching the query set alone changes the result in the same cycle.
        @(negedge clk);
        qry_set = 4'd3;
        #1;
        chk("R2 query set 3", int'(victim_way), peek_set_victim(3));
        qry_set = 4'd5;
        #1;
        chk("R2 query set 5", int'(victim_way), peek_set_victim(5));
        // R3: an update of the queried set shows only after the edge.
        @(negedge clk);
        upd_en  = 1'b1;
        upd_set = 4'd7;
        upd_way = 3'd0;
        qry_set = 4'd7;
        #1;
        chk("R3 old victim before edge", int'(victim_way), 0);
        @(negedge clk);
        upd_en = 1'b0;
        mdl_touch(7, 0);
        #1;
        chk("R3 new victim after edge", int'(victim_way), 4);
    endtask

    task automatic t_fill_victim;
        for (int i = 0; i < 6; i++) begin
            int v;
            qry_set = 4'd9;
            #1;
            v = int'(victim_way);
            chk("R9 victim before fill", v, mdl_victim(9));
            touch(9, v);
            qry_set = 4'd9;
            #1;
            chk("R9 victim moves after fill", int'(victim_way != WW'(v)), 1);
        end
    endtask

    task automatic t_mixed;
        for (int i = 0; i < 300; i++) begin
            int s, w;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[3:0]);
            w = lfsr[9] ? mdl_victim(s) : int'(lfsr[6:4]);
            touch(s, w);
            qry_set = SW'(s);
            #1;
            chk("R7 mixed updated set", int'(victim_way), mdl_victim(s));
            qry_set = SW'(lfsr[13:10]);
            #1;
            chk("R4 mixed other set", int'(victim_way), mdl_victim(int'(lfsr[13:10])));
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 200000);
        finish_run();
    end

    initial begin
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_all();
        t_bit_reversed();
        t_set_isolation();
        t_enable_low();
        t_timing();
        t_fill_victim();
        t_mixed();
        finish_run();
    end

endmodule